// File: doc/BRIEF.md
# UART Status Flag Register

This block keeps the status flags of a serial port and presents them as one 32-bit read-only word. The receive side hands it single-cycle pulses (character complete, framing fault, parity fault) together with the received character. The block keeps that character in a receive holding register and flags a lost character when a new one arrives before the previous one was read. The transmit side supplies level signals that show whether its holding register is occupied and whether its shifter is busy. Enable levels for each direction qualify everything.

Three bus strobes act on the flags. A receive-holding read consumes the held character. A transmit-holding write marks the holding register as taken. A clear-status command clears the sticky error and match flags. The block also compares each received character against a programmed inclusive value window. It can optionally require correct parity, and it raises a sticky match flag on a hit. Sampling the status word itself never changes any flag.

Top module: `uart_status_reg`

## Requirements
- R1: The status word has rx_avail at bit 0, tx_free at bit 1, ovr at bit 5, frm at bit 6, par at bit 7, tx_idle at bit 9 and cmp at bit 15. Every other bit always reads 0.
- R2: After reset every status bit reads 0, and so does rhr_data_o.
- R3: With the receiver enabled, a cycle with rx_done_i high sets rx_avail and loads rx_data_i into rhr_data_o. Both are visible after the next rising edge.
- R4: rx_avail clears on the edge after an rhr_rd_i strobe that has no rx_done_i in the same cycle. It reads 0 on the edge after rx_en_i goes low. While the receiver is disabled, rx_done_i, rx_frm_err_i and rx_par_err_i have no effect on any flag or on rhr_data_o.
- R5: tx_free is 1 on the edge after a cycle in which tx_en_i is 1, thr_full_i is 0 and thr_wr_i is 0. Otherwise it is 0.
- R6: tx_idle is 1 on the edge after a cycle in which tx_en_i is 1, thr_full_i is 0, tx_busy_i is 0 and thr_wr_i is 0. Otherwise it is 0.
- R7: frm and par are set by an enabled rx_frm_err_i or rx_par_err_i pulse. Like ovr and cmp, they then hold at 1 until a rst_sta_i strobe, which clears all four flags on the next edge.
- R8: cmp is set when an enabled character satisfies cmp_lo_i <= rx_data_i <= cmp_hi_i (unsigned, bounds included). When cmp_par_chk_i is 1, the same cycle must also have rx_par_err_i low.
- R9: ovr is set when an enabled character completes while rx_avail is 1 and rhr_rd_i is low in that cycle. The new character replaces the held one.
- R10: When a set event and rst_sta_i (or, for rx_avail, rhr_rd_i) fall in the same cycle, the flag ends up at 1.
- R11: Flags change only through the events above. With no event and no strobe, the status word stays constant however long it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable level |
| tx_en_i | input | 1 | Transmitter enable level |
| rx_done_i | input | 1 | Character complete pulse |
| rx_data_i | input | DATA_W | Received character, valid with rx_done_i |
| rx_frm_err_i | input | 1 | Framing fault pulse |
| rx_par_err_i | input | 1 | Parity fault pulse |
| cmp_lo_i | input | DATA_W | Lower bound of match window |
| cmp_hi_i | input | DATA_W | Upper bound of match window |
| cmp_par_chk_i | input | 1 | Match also requires correct parity |
| thr_full_i | input | 1 | Transmit holding register occupied |
| tx_busy_i | input | 1 | Transmit shifter active |
| rhr_rd_i | input | 1 | Receive holding read strobe |
| thr_wr_i | input | 1 | Transmit holding write strobe |
| rst_sta_i | input | 1 | Clear-status strobe |
| status_o | output | 32 | Status word |
| rhr_data_o | output | DATA_W | Receive holding register |

## Verification
Two pairs of actions can coincide and are driven into the same cycle on purpose. The first is a clear-status strobe together with a framing fault pulse. The second is a receive-holding read together with a new character completion. In each case the flag must read 1 on the following edge, which shows the set path wins. A read that coincides with a new character must also leave ovr at 0, and ovr must rise when no read accompanies the second character.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int unsigned STAT_W = 32;
  localparam int unsigned BIT_RX_AVAIL = 0;
  localparam int unsigned BIT_TX_FREE  = 1;
  localparam int unsigned BIT_OVR      = 5;
  localparam int unsigned BIT_FRM      = 6;
  localparam int unsigned BIT_PAR      = 7;
  localparam int unsigned BIT_TX_IDLE  = 9;
  localparam int unsigned BIT_CMP      = 15;

  localparam int unsigned NUM_STK = 4;
  localparam int unsigned STK_OVR = 0;
  localparam int unsigned STK_FRM = 1;
  localparam int unsigned STK_PAR = 2;
  localparam int unsigned STK_CMP = 3;

  typedef struct packed {
    logic               rx_avail;
    logic               tx_free;
    logic               tx_idle;
    logic [NUM_STK-1:0] stk;
  } flags_t;

  function automatic logic [STAT_W-1:0] pack_status(flags_t f);
    logic [STAT_W-1:0] w;
    w               = '0;
    w[BIT_RX_AVAIL] = f.rx_avail;
    w[BIT_TX_FREE]  = f.tx_free;
    w[BIT_OVR]      = f.stk[STK_OVR];
    w[BIT_FRM]      = f.stk[STK_FRM];
    w[BIT_PAR]      = f.stk[STK_PAR];
    w[BIT_TX_IDLE]  = f.tx_idle;
    w[BIT_CMP]      = f.stk[STK_CMP];
    return w;
  endfunction
endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_i,
  output logic              avail_o,
  output logic              ovr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              avail_q;
  logic [DATA_W-1:0] data_q;
  logic              take;

  assign take = rx_en_i & done_i;
  // lost character: new one lands on an unread one
  assign ovr_o = take & avail_q & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avail_q <= 1'b0;
    end else if (!rx_en_i) begin
      avail_q <= 1'b0;
    end else if (take) begin
      avail_q <= 1'b1;
    end else if (rd_i) begin
      avail_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (take) data_q <= data_i;
  end

  assign avail_o = avail_q;
  assign data_o  = data_q;
endmodule

// File: rtl/uart_cmp_match.sv
module uart_cmp_match #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic              par_chk_i,
  input  logic              par_err_i,
  output logic              hit_o
);
  logic in_win;
  logic par_ok;

  assign in_win = (data_i >= lo_i) && (data_i <= hi_i);
  assign par_ok = ~par_chk_i | ~par_err_i;
  assign hit_o  = take_i & in_win & par_ok;
endmodule

// File: rtl/uart_sticky_flags.sv
module uart_sticky_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= set_i[i] | (q & ~clr_i);  // set wins
    end
    assign flag_o[i] = q;
  end
endmodule

// File: rtl/uart_tx_flags.sv
module uart_tx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic thr_full_i,
  input  logic tx_busy_i,
  input  logic thr_wr_i,
  output logic free_o,
  output logic idle_o
);
  logic free_q, idle_q, hold_clear;

  // a write blocks both flags until the occupancy level catches up
  assign hold_clear = tx_en_i & ~thr_full_i & ~thr_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      free_q <= hold_clear;
      idle_q <= hold_clear & ~tx_busy_i;
    end
  end

  assign free_o = free_q;
  assign idle_o = idle_q;
endmodule

// File: rtl/uart_status_reg.sv
module uart_status_reg
  import uart_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              tx_en_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_frm_err_i,
  input  logic              rx_par_err_i,
  input  logic [DATA_W-1:0] cmp_lo_i,
  input  logic [DATA_W-1:0] cmp_hi_i,
  input  logic              cmp_par_chk_i,
  input  logic              thr_full_i,
  input  logic              tx_busy_i,
  input  logic              rhr_rd_i,
  input  logic              thr_wr_i,
  input  logic              rst_sta_i,
  output logic [31:0]       status_o,
  output logic [DATA_W-1:0] rhr_data_o
);
  flags_t             fl;
  logic               ovr_evt, hit_evt;
  logic [NUM_STK-1:0] stk_set;

  uart_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_en_i (rx_en_i),
    .done_i  (rx_done_i),
    .data_i  (rx_data_i),
    .rd_i    (rhr_rd_i),
    .avail_o (fl.rx_avail),
    .ovr_o   (ovr_evt),
    .data_o  (rhr_data_o)
  );

  uart_cmp_match #(.DATA_W(DATA_W)) u_cmp (
    .take_i    (rx_en_i & rx_done_i),
    .data_i    (rx_data_i),
    .lo_i      (cmp_lo_i),
    .hi_i      (cmp_hi_i),
    .par_chk_i (cmp_par_chk_i),
    .par_err_i (rx_par_err_i),
    .hit_o     (hit_evt)
  );

  always_comb begin
    stk_set          = '0;
    stk_set[STK_OVR] = ovr_evt;
    stk_set[STK_FRM] = rx_en_i & rx_frm_err_i;
    stk_set[STK_PAR] = rx_en_i & rx_par_err_i;
    stk_set[STK_CMP] = hit_evt;
  end

  uart_sticky_flags #(.N(NUM_STK)) u_stk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (stk_set),
    .clr_i  (rst_sta_i),
    .flag_o (fl.stk)
  );

  uart_tx_flags u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_en_i    (tx_en_i),
    .thr_full_i (thr_full_i),
    .tx_busy_i  (tx_busy_i),
    .thr_wr_i   (thr_wr_i),
    .free_o     (fl.tx_free),
    .idle_o     (fl.tx_idle)
  );

  assign status_o = pack_status(fl);
endmodule

// File: rtl/uart_status_chk.sv
module uart_status_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rx_en_i,
  input logic        rx_done_i,
  input logic        rx_frm_err_i,
  input logic        rhr_rd_i,
  input logic        thr_wr_i,
  input logic        rst_sta_i,
  input logic [31:0] status_i
);
  localparam logic [31:0] DEF_MASK = 32'h0000_82E3;

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i & ~DEF_MASK) == 32'h0);  // R1
  AST_RX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_i && rx_done_i |=> status_i[0]);  // R3
  AST_RX_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i || (rhr_rd_i && !rx_done_i)) |=> !status_i[0]);  // R4
  AST_WR_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> !status_i[1] && !status_i[9]);  // R5
  AST_IDLE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_i[9] |-> status_i[1]);  // R6
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_sta_i |=> ((status_i & 32'h80E0) & $past(status_i & 32'h80E0)) == $past(status_i & 32'h80E0));  // R7
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_i && rx_done_i && status_i[0] && !rhr_rd_i |=> status_i[5]);  // R9
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_sta_i && rx_en_i && rx_frm_err_i |=> status_i[6]);  // R10
endmodule

bind uart_status_reg uart_status_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_en_i      (rx_en_i),
  .rx_done_i    (rx_done_i),
  .rx_frm_err_i (rx_frm_err_i),
  .rhr_rd_i     (rhr_rd_i),
  .thr_wr_i     (thr_wr_i),
  .rst_sta_i    (rst_sta_i),
  .status_i     (status_o)
);

// File: tb/sim_uart_status_reg.sv
`timescale 1ns/1ps
module sim_uart_status_reg;
  localparam int unsigned DATA_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 0, tx_en = 0, rx_done = 0, frm = 0, par = 0, par_chk = 0;
  logic thr_full = 0, busy = 0, rd = 0, wr = 0, rst_sta = 0;
  logic [DATA_W-1:0] rx_data = '0, lo = '0, hi = '0;
  logic [31:0] status;
  logic [DATA_W-1:0] rhr;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  uart_status_reg #(.DATA_W(DATA_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .tx_en_i(tx_en),
    .rx_done_i(rx_done), .rx_data_i(rx_data), .rx_frm_err_i(frm),
    .rx_par_err_i(par), .cmp_lo_i(lo), .cmp_hi_i(hi),
    .cmp_par_chk_i(par_chk), .thr_full_i(thr_full), .tx_busy_i(busy),
    .rhr_rd_i(rd), .thr_wr_i(wr), .rst_sta_i(rst_sta),
    .status_o(status), .rhr_data_o(rhr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of stimulus; inputs return to idle, result visible at the next negedge
  task automatic step();
    @(negedge clk);
    rx_done = 0; frm = 0; par = 0; rd = 0; wr = 0; rst_sta = 0;
  endtask

  task automatic send(logic [7:0] d);
    rx_done = 1; rx_data = d; step();
  endtask

  task automatic clr_all();
    rst_sta = 1; rd = 1; step();
  endtask

  task automatic t_reset();
    check("R2 status", status, 32'h0);
    check("R2 rhr", {24'h0, rhr}, 32'h0);
    rx_en = 1; tx_en = 1; step();
    check("R1 idle word", status, 32'h0000_0202);
  endtask

  task automatic t_rx();
    send(8'h41);
    check("R3 avail", status, 32'h0000_0203);
    check("R3 data", {24'h0, rhr}, 32'h41);
    rd = 1; step();
    check("R4 read clears", status, 32'h0000_0202);
  endtask

  task automatic t_ovr();
    send(8'h11);
    send(8'h22);
    check("R9 ovr set", status, 32'h0000_0223);
    check("R9 replaced", {24'h0, rhr}, 32'h22);
    clr_all();
    send(8'h33);
    rd = 1; rx_done = 1; rx_data = 8'h44; step();
    check("R10 read+char keeps avail, no ovr", status, 32'h0000_0203);
    clr_all();
  endtask

  task automatic t_errs();
    frm = 1; step();
    par = 1; step();
    for (int i = 0; i < 6; i++) step();
    check("R7 R11 sticky errs", status, 32'h0000_02C2);
    rst_sta = 1; step();
    check("R7 clear", status, 32'h0000_0202);
    rst_sta = 1; frm = 1; step();
    check("R10 set wins", status, 32'h0000_0242);
    clr_all();
  endtask

  task automatic t_cmp();
    lo = 8'h30; hi = 8'h39; par_chk = 0;
    send(8'h39); rd = 1; step();
    check("R8 upper bound", status, 32'h0000_8202);
    clr_all();
    send(8'h3A); rd = 1; step();
    check("R8 above window", status, 32'h0000_0202);
    send(8'h30); rd = 1; step();
    check("R8 lower bound", status, 32'h0000_8202);
    clr_all();
    send(8'h2F); rd = 1; step();
    check("R8 below window", status, 32'h0000_0202);
    par_chk = 1; par = 1; send(8'h35); rd = 1; step();
    check("R8 parity required", status, 32'h0000_0282);
    clr_all();
    par_chk = 0; par = 1; send(8'h35); rd = 1; step();
    check("R8 parity ignored", status, 32'h0000_8282);
    clr_all();
  endtask

  task automatic t_rxdis();
    send(8'h55);
    rx_en = 0; step();
    check("R4 disable clears", status, 32'h0000_0202);
    frm = 1; par = 1; send(8'h66);
    check("R4 disabled ignores", status, 32'h0000_0202);
    check("R4 rhr kept", {24'h0, rhr}, 32'h55);
    rx_en = 1; step();
  endtask

  task automatic t_tx();
    wr = 1; step();
    check("R5 R6 write blocks", status, 32'h0);
    thr_full = 1; step();
    check("R5 holding full", status, 32'h0);
    thr_full = 0; busy = 1; step(); step();
    check("R6 shifter busy", status, 32'h0000_0002);
    busy = 0; step(); step();
    check("R6 idle", status, 32'h0000_0202);
    tx_en = 0; step(); step();
    check("R5 R6 tx disabled", status, 32'h0);
    tx_en = 1; step(); step();
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rx();
    t_ovr();
    t_errs();
    t_cmp();
    t_rxdis();
    t_tx();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule